// File: doc/BRIEF.md
# Flash Protected Range Checker

This block guards the flash cycle engine against accesses to protected parts of the flash. It holds five range registers. Each register describes one window of the 25-bit flash linear address space at 4 KiB granularity, and each window has its own read-protect and write-protect enable. For every pending cycle the engine presents the linear address and the direction of the access. The block answers in the same cycle: it raises a block flag and gives the index of the lowest-numbered range that matched.

The range registers are written through a simple port that also reads back the register selected by the index. Once the lockdown input has been seen high, the registers are frozen and stay frozen until the next reset. A register word uses this layout:

| Bits | Field |
|------|-------|
| 31 | Write-protect enable (write/erase accesses) |
| 28:16 | Upper limit, as address bits [24:12]; the low 12 bits are taken as 0xFFF |
| 15 | Read-protect enable |
| 12:0 | Lower limit, as address bits [24:12]; the low 12 bits are taken as 0x000 |

Top module: `flash_range_guard`

## Requirements
- R1: While the block is not locked, a write with cfg_we_i=1 and cfg_idx_i in 0..4 stores cfg_wdata_i into that range register. cfg_rdata_o returns the selected register from the next cycle.
- R2: Bits [30:29] and [14:13] of every register always read as zero, whatever value was written to them.
- R3: A write with cfg_idx_i in 5..7 changes no register, and a read of index 5..7 returns zero.
- R4: Lockdown is sticky. A write in the same cycle as lock_i=1, or in any later cycle, is ignored. Only a reset clears the lock.
- R5: A read access (chk_wr_i=0) is blocked when lower ≤ chk_addr_i[24:12] ≤ upper in a range whose bit 15 is set.
- R6: A write/erase access (chk_wr_i=1) is blocked when the address lies in a range whose bit 31 is set. The enable for one direction has no effect on the other direction.
- R7: A range whose lower limit is greater than its upper limit matches no address.
- R8: When several ranges match, hit_idx_o gives the lowest-numbered one. hit_idx_o is 0 when block_o is 0.
- R9: block_o and hit_idx_o follow the address and direction in the same cycle. A register write changes the checking result only from the next cycle on.
- R10: After reset, all registers read zero, nothing is blocked and the block is unlocked.
- R11: block_o is 0 whenever chk_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Lockdown request, sticky once seen |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Register index for write and readback |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Readback of the selected register |
| chk_valid_i | input | 1 | A flash cycle is pending |
| chk_wr_i | input | 1 | 1 = write/erase, 0 = read |
| chk_addr_i | input | 25 | Flash linear address |
| block_o | output | 1 | Cycle must not be issued |
| hit_idx_o | output | 3 | Lowest matching range index |

## Verification
A register write and a check that depends on that register can happen in the same cycle, and so can a write and a lockdown request. The bench provokes the first case by programming a range while it presents an address inside that range. It expects no block in that cycle and a block in the next. It provokes the second case by raising lock_i together with a write strobe and then reading the register back. The expected results come from a bench model that applies writes only after computing the current cycle's answer, and that drops any write seen together with, or after, lockdown.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int ADDR_W = 25;
  localparam int PAGE_W = 12;
  localparam int LIM_W  = ADDR_W - PAGE_W;
  localparam int REG_W  = 32;
  localparam int WP_BIT = 31;
  localparam int RP_BIT = 15;
  localparam int HI_LSB = 16;
  localparam int LO_LSB = 0;

  typedef struct packed {
    logic             wp;
    logic             rp;
    logic [LIM_W-1:0] hi;
    logic [LIM_W-1:0] lo;
  } range_t;

  function automatic range_t unpack_range(input logic [REG_W-1:0] w);
    range_t r;
    r.wp = w[WP_BIT];
    r.rp = w[RP_BIT];
    r.hi = w[HI_LSB +: LIM_W];
    r.lo = w[LO_LSB +: LIM_W];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_range(input range_t r);
    logic [REG_W-1:0] w;
    w = '0;
    w[WP_BIT] = r.wp;
    w[RP_BIT] = r.rp;
    w[HI_LSB +: LIM_W] = r.hi;
    w[LO_LSB +: LIM_W] = r.lo;
    return w;
  endfunction
endpackage

// File: rtl/frg_range_reg.sv
module frg_range_reg
  import frg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             locked_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output range_t           range_o
);
  range_t range_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   range_q <= '0;
    else if (wr_en_i && !locked_i) range_q <= unpack_range(wdata_i);
  end

  assign range_o = range_q;

  logic unused_rsvd;
  assign unused_rsvd = ^{wdata_i[30:29], wdata_i[14:13]};

  assert_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(range_q));
endmodule

// File: rtl/frg_range_match.sv
module frg_range_match
  import frg_pkg::*;
(
  input  range_t           range_i,
  input  logic [LIM_W-1:0] page_i,
  input  logic             wr_i,
  output logic             hit_o
);
  logic en, in_win;
  assign en     = wr_i ? range_i.wp : range_i.rp;
  // inverted limits give an empty window naturally
  assign in_win = (page_i >= range_i.lo) && (page_i <= range_i.hi);
  assign hit_o  = en && in_win;
endmodule

// File: rtl/frg_prio_pick.sv
module frg_prio_pick #(
  parameter int N    = 5,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = $clog2(NUM_RANGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              chk_valid_i,
  input  logic              chk_wr_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              block_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  localparam logic [REG_W-1:0] RSVD_MASK = 32'h6000_6000;

  logic                  lock_q, locked;
  logic [LIM_W-1:0]      page;
  logic [NUM_RANGES-1:0] wr_sel, hit;
  range_t                ranges [NUM_RANGES];
  logic                  any_hit;
  logic [IDX_W-1:0]      pick_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_q <= 1'b0;
    else if (lock_i) lock_q <= 1'b1;
  end

  // lockdown applies in the cycle it is raised
  assign locked = lock_q | lock_i;
  assign page   = chk_addr_i[ADDR_W-1:PAGE_W];

  logic unused_low;
  assign unused_low = ^chk_addr_i[PAGE_W-1:0];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    assign wr_sel[g] = cfg_we_i && (cfg_idx_i == IDX_W'(g));

    frg_range_reg u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .locked_i (locked),
      .wr_en_i  (wr_sel[g]),
      .wdata_i  (cfg_wdata_i),
      .range_o  (ranges[g])
    );

    frg_range_match u_match (
      .range_i (ranges[g]),
      .page_i  (page),
      .wr_i    (chk_wr_i),
      .hit_o   (hit[g])
    );
  end

  frg_prio_pick #(.N(NUM_RANGES), .IDXW(IDX_W)) u_pick (
    .req_i (hit),
    .any_o (any_hit),
    .idx_o (pick_idx)
  );

  assign block_o   = chk_valid_i && any_hit;
  assign hit_idx_o = block_o ? pick_idx : '0;

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (cfg_idx_i == IDX_W'(i)) cfg_rdata_o = pack_range(ranges[i]);
  end

  assert_lock_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  assert_no_block_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |-> !block_o);
  assert_idx_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !block_o |-> (hit_idx_o == '0));
  assert_idx_hits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> hit[hit_idx_o]);
  assert_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> ((hit & ((NUM_RANGES'(1) << hit_idx_o) - NUM_RANGES'(1))) == '0));
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cfg_rdata_o & RSVD_MASK) == 0);
endmodule

// File: tb/sim_flash_range_guard.sv
module sim_flash_range_guard;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        chk_valid_i = 1'b0;
  logic        chk_wr_i = 1'b0;
  logic [24:0] chk_addr_i = '0;
  logic        block_o;
  logic [2:0]  hit_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  flash_range_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i), .cfg_we_i(cfg_we_i),
    .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .chk_valid_i(chk_valid_i), .chk_wr_i(chk_wr_i), .chk_addr_i(chk_addr_i),
    .block_o(block_o), .hit_idx_o(hit_idx_o)
  );

  // bench model of the register file
  logic [31:0] mreg [8];
  bit          mlock;

  string       q_tag [$];
  logic        q_blk [$];
  logic [2:0]  q_idx [$];
  logic [31:0] q_rd  [$];

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mlock = 0;
  endfunction

  task automatic step(input string tag, input logic we, input logic [2:0] idx,
                      input logic [31:0] wd, input logic valid, input logic wr,
                      input logic [24:0] addr, input logic lk);
    logic eb;
    logic [2:0] ei;
    logic [12:0] pg, lo, hi;
    logic en;
    @(posedge clk); #1;
    cfg_we_i = we; cfg_idx_i = idx; cfg_wdata_i = wd;
    chk_valid_i = valid; chk_wr_i = wr; chk_addr_i = addr; lock_i = lk;
    eb = 0; ei = 0; pg = addr[24:12];
    for (int i = 4; i >= 0; i--) begin
      lo = mreg[i][12:0]; hi = mreg[i][28:16];
      en = wr ? mreg[i][31] : mreg[i][15];
      if (valid && en && lo <= pg && pg <= hi) begin eb = 1; ei = 3'(i); end
    end
    q_tag.push_back(tag); q_blk.push_back(eb); q_idx.push_back(ei);
    q_rd.push_back(idx < 5 ? mreg[idx] : 32'h0);
    if (lk) mlock = 1;
    if (we && !mlock && idx < 5) mreg[idx] = wd & 32'h9FFF_9FFF;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q_tag.size() > 0) begin
        string t; logic b; logic [2:0] x; logic [31:0] r;
        t = q_tag.pop_front(); b = q_blk.pop_front();
        x = q_idx.pop_front(); r = q_rd.pop_front();
        checks += 3;
        if (block_o !== b) begin
          fails++; $display("FAIL %s block_o act %0b exp %0b", t, block_o, b);
        end
        if (hit_idx_o !== x) begin
          fails++; $display("FAIL %s hit_idx_o act %0d exp %0d", t, hit_idx_o, x);
        end
        if (cfg_rdata_o !== r) begin
          fails++; $display("FAIL %s cfg_rdata_o act %h exp %h", t, cfg_rdata_o, r);
        end
      end
    end
  end

  function automatic logic [31:0] rw(bit wp, bit rp, logic [12:0] lo, logic [12:0] hi);
    return {wp, 2'b00, hi, rp, 2'b00, lo};
  endfunction

  task automatic do_reset();
    @(posedge clk); #1; rst_ni = 0;
    cfg_we_i = 0; lock_i = 0; chk_valid_i = 0;
    model_reset();
    @(posedge clk); #1; rst_ni = 1;
  endtask

  initial begin
    model_reset();
    #5 rst_ni = 1;
    // R10 reset state
    for (int i = 0; i < 5; i++) step("R10", 0, 3'(i), 0, 1, i[0], 25'h10000, 0);
    // R1 R2 program ranges, reserved bits set in writes
    step("R1", 1, 0, rw(0,1,13'h010,13'h01F) | 32'h6000_6000, 0, 0, 0, 0);
    step("R2", 1, 1, rw(1,0,13'h018,13'h020) | 32'h6000_6000, 0, 0, 0, 0);
    step("R1", 1, 3, rw(1,1,13'h050,13'h040), 0, 0, 0, 0);
    step("R1", 1, 4, rw(1,0,13'h01C,13'h1FFF), 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R1", 0, 3'(i), 0, 0, 0, 0, 0);
    // R9 same-cycle write and check of range 2
    step("R9", 1, 2, rw(1,1,13'h100,13'h100), 1, 0, 25'h100000, 0);
    step("R9", 0, 2, 0, 1, 0, 25'h100000, 0);
    // R5 read boundaries on range 0
    step("R5", 0, 0, 0, 1, 0, 25'h010000, 0);
    step("R5", 0, 0, 0, 1, 0, 25'h00FFFF, 0);
    step("R5", 0, 0, 0, 1, 0, 25'h01FFFF, 0);
    step("R5", 0, 0, 0, 1, 0, 25'h020000, 0);
    // R6 write on range 1, read enable not used for writes
    step("R6", 0, 1, 0, 1, 1, 25'h018000, 0);
    step("R6", 0, 1, 0, 1, 1, 25'h017FFF, 0);
    step("R6", 0, 1, 0, 1, 0, 25'h019000, 0);
    step("R6", 0, 1, 0, 1, 1, 25'h012000, 0);
    // R8 overlaps
    step("R8", 0, 4, 0, 1, 1, 25'h01C000, 0);
    step("R8", 0, 4, 0, 1, 1, 25'h100ABC, 0);
    step("R8", 0, 4, 0, 1, 1, 25'h1FFFFFF, 0);
    step("R8", 0, 4, 0, 1, 0, 25'h01C000, 0);
    // R7 inverted range 3
    step("R7", 0, 3, 0, 1, 0, 25'h045000, 0);
    step("R7", 0, 3, 0, 1, 0, 25'h050000, 0);
    step("R7", 0, 3, 0, 1, 0, 25'h040000, 0);
    // R11 valid low
    step("R11", 0, 0, 0, 0, 1, 25'h100000, 0);
    step("R11", 0, 0, 0, 0, 0, 25'h010000, 0);
    // R3 out-of-range index
    step("R3", 1, 5, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R3", 1, 7, 32'hFFFF_FFFF, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R3", 0, 3'(i), 0, 1, 1, 25'h000000, 0);
    // R4 write in lock cycle ignored, later writes ignored
    step("R4", 1, 0, rw(1,1,13'h0,13'h1FFF), 0, 0, 0, 1);
    step("R4", 0, 0, 0, 1, 1, 25'h000000, 0);
    step("R4", 1, 3, rw(1,1,13'h0,13'h1FFF), 0, 0, 0, 0);
    step("R4", 0, 3, 0, 1, 0, 25'h045000, 0);
    step("R4", 0, 0, 0, 1, 0, 25'h010000, 0);
    // R4 reset clears lock, R10 state after reset
    @(negedge clk);
    do_reset();
    step("R10", 0, 0, 0, 1, 0, 25'h010000, 0);
    step("R4", 1, 0, rw(0,1,13'h0,13'h0), 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 25'h000123, 0);
    step("R4", 0, 0, 0, 1, 1, 25'h000123, 0);
    @(posedge clk); @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule